// File: doc/BRIEF.md
# Split Read/Write Memory Responder

This block answers memory requests from a small stack processor that drives separate read and write request ports. Each port has its own address, its own one-cycle request strobe and its own busy flag, so one read and one write can be in flight together, as with a dual-port RAM. Behind the ports sits a word-addressed storage array. Writes carry a mask with one bit per data bit. A fixed, per-port number of wait states can be set, and zero wait states is a legal setting.

Busy is the only back-pressure. A requester may pulse a port's strobe only in a cycle where that port's busy is low. Read data cannot be stalled: it is presented for exactly one cycle with `rd_valid` high and must be taken in that cycle. A request made while its port is busy is a protocol violation. The block discards that request and raises a one-cycle error flag for that port. The address, data and mask of a request are sampled only in the strobe cycle. A request takes effect on the storage at its completion edge, which is the request edge itself when the port has zero wait states.

Top module: `srw_mem_responder`

## Requirements
- R1: A write changes only the addressed word, and within it only the bits whose `wr_mask` bit is 1. Bits whose mask bit is 0 keep their previous value, and a zero mask leaves the word unchanged.
- R2: A legal read returns the word on `rd_data`, with `rd_valid` high for exactly one cycle. That cycle is the one after the RD_WAIT-th edge that follows the request edge, and `rd_busy` is low in it.
- R3: After a legal request on a port whose wait count N is nonzero, that port's busy is high for exactly N cycles, starting in the cycle after the request edge.
- R4: The two ports are independent. A read and a write may be requested in the same cycle, and both may be busy at once.
- R5: A request made while its port's busy is high sets that port's error flag (`rd_err` or `wr_err`) in the next cycle only. The request is ignored: no memory change, no restart of the busy window, and no change to the returned read data.
- R6: When a read and a write take effect at the same edge on the same word, the read returns the contents from before the write.
- R7: A synchronous reset, `rst` high at a clock edge, clears both busy flags, both error flags, `rd_valid` and any request still pending. The memory contents are kept.
- R8: A port with zero wait states never raises its busy flag. Each such read presents its data in the cycle right after the request, including on back-to-back requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | One-cycle write request strobe |
| wr_addr | input | ADDR_W | Word index for the write |
| wr_data | input | DATA_W | Write data |
| wr_mask | input | DATA_W | Per-bit write mask; 1 means update |
| wr_busy | output | 1 | Write port busy; a write request is illegal while high |
| wr_err | output | 1 | One-cycle flag for an illegal write request |
| rd_en | input | 1 | One-cycle read request strobe |
| rd_addr | input | ADDR_W | Word index for the read |
| rd_busy | output | 1 | Read port busy; a read request is illegal while high |
| rd_valid | output | 1 | Read data valid, high for one cycle |
| rd_data | output | DATA_W | Read data |
| rd_err | output | 1 | One-cycle flag for an illegal read request |

## Verification
The bench builds two copies of the block with the default 32-bit data and 12-bit address widths. The first has zero wait states on both ports. It runs a vector table of back-to-back masked writes and reads, which makes the same-edge read-before-write case and the top address reachable. The second has two read wait states and three write wait states. It is used for busy-window lengths, the placement of the data-valid cycle, overlapping read and write traffic, requests made while busy, and a reset that arrives while a read is outstanding.

// File: rtl/srw_pkg.sv
package srw_pkg;
  localparam int DEF_DATA_W = 32;
  localparam int DEF_ADDR_W = 12;

  // bits needed to hold a count from 0 to n
  function automatic int cnt_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/srw_req_slot.sv
// One request port: busy window, illegal-request flag and held payload.
module srw_req_slot #(
  parameter int WAIT = 0,
  parameter int PW   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [PW-1:0] pay_in,
  output logic          busy,
  output logic          err,
  output logic          fire,
  output logic [PW-1:0] pay_out
);
  logic err_q;

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= req & busy;
  end
  assign err = err_q;

  generate
    if (WAIT == 0) begin : g_zero
      // the request completes at its own edge
      assign busy    = 1'b0;
      assign fire    = req;
      assign pay_out = pay_in;
    end else begin : g_wait
      localparam int CW = srw_pkg::cnt_bits(WAIT);
      localparam logic [CW-1:0] LOAD = CW'(WAIT);
      logic [CW-1:0] cnt;
      logic [PW-1:0] pay_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt <= '0;
        end else if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else if (req) begin
          cnt <= LOAD;
        end
      end

      always_ff @(posedge clk) begin
        if (req && cnt == '0) pay_q <= pay_in;
      end

      assign busy    = (cnt != '0);
      assign fire    = (cnt == CW'(1));
      assign pay_out = pay_q;
    end
  endgenerate
endmodule

// File: rtl/srw_mem_array.sv
// Word array with a per-bit masked write port and a registered read port.
module srw_mem_array #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] wmask,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  // nonblocking updates: a read at the same edge sees the old word
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= (store[waddr] & ~wmask) | (wdata & wmask);
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/srw_mem_responder.sv
module srw_mem_responder #(
  parameter int DATA_W  = srw_pkg::DEF_DATA_W,
  parameter int ADDR_W  = srw_pkg::DEF_ADDR_W,
  parameter int RD_WAIT = 1,
  parameter int WR_WAIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] wr_mask,
  output logic              wr_busy,
  output logic              wr_err,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_err
);
  localparam int WPW = ADDR_W + 2 * DATA_W;

  logic              rd_fire, wr_fire;
  logic [ADDR_W-1:0] rd_addr_eff;
  logic [WPW-1:0]    wr_pay_eff;
  logic              rd_go, wr_go;
  logic              rd_valid_q;

  srw_req_slot #(.WAIT(RD_WAIT), .PW(ADDR_W)) u_rd_slot (
    .clk     (clk),
    .rst     (rst),
    .req     (rd_en),
    .pay_in  (rd_addr),
    .busy    (rd_busy),
    .err     (rd_err),
    .fire    (rd_fire),
    .pay_out (rd_addr_eff)
  );

  srw_req_slot #(.WAIT(WR_WAIT), .PW(WPW)) u_wr_slot (
    .clk     (clk),
    .rst     (rst),
    .req     (wr_en),
    .pay_in  ({wr_addr, wr_data, wr_mask}),
    .busy    (wr_busy),
    .err     (wr_err),
    .fire    (wr_fire),
    .pay_out (wr_pay_eff)
  );

  assign rd_go = rd_fire & ~rst;
  assign wr_go = wr_fire & ~rst;

  srw_mem_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
    .clk   (clk),
    .we    (wr_go),
    .waddr (wr_pay_eff[WPW-1 -: ADDR_W]),
    .wdata (wr_pay_eff[2*DATA_W-1 -: DATA_W]),
    .wmask (wr_pay_eff[DATA_W-1:0]),
    .re    (rd_go),
    .raddr (rd_addr_eff),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid_q <= 1'b0;
    else     rd_valid_q <= rd_go;
  end
  assign rd_valid = rd_valid_q;
endmodule

// File: rtl/srw_mem_responder_chk.sv
module srw_mem_responder_chk #(
  parameter int RD_WAIT = 1,
  parameter int WR_WAIT = 1
) (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic wr_busy,
  input logic wr_err,
  input logic rd_en,
  input logic rd_busy,
  input logic rd_valid,
  input logic rd_err
);
  assert_rd_err_R5: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_busy |=> rd_err);

  assert_wr_err_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_busy |=> wr_err);

  assert_rd_busy_rise_R3: assert property (@(posedge clk) disable iff (rst)
    (RD_WAIT > 0) && rd_en && !rd_busy |=> rd_busy);

  assert_wr_busy_rise_R3: assert property (@(posedge clk) disable iff (rst)
    (WR_WAIT > 0) && wr_en && !wr_busy |=> wr_busy);

  assert_valid_at_busy_end_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_busy) && !$past(rst) |-> rd_valid);

  assert_valid_not_busy_R2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !rd_busy);

  assert_zero_wait_data_R8: assert property (@(posedge clk) disable iff (rst)
    (RD_WAIT == 0) && rd_en |=> rd_valid);

  assert_reset_clear_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !rd_busy && !wr_busy && !rd_valid && !rd_err && !wr_err);
endmodule

bind srw_mem_responder srw_mem_responder_chk #(
  .RD_WAIT(RD_WAIT), .WR_WAIT(WR_WAIT)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_busy(wr_busy), .wr_err(wr_err),
  .rd_en(rd_en), .rd_busy(rd_busy), .rd_valid(rd_valid), .rd_err(rd_err)
);

// File: tb/tb_srw_mem_responder.sv
`timescale 1ns/1ps
module tb_srw_mem_responder;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam int VW = 1 + AW + DW + DW + 1 + AW + DW;
  localparam int NV = 10;

  // vector: wr, waddr, wdata, wmask, rd, raddr, expected read data
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 12'h010, 32'h12345678, 32'hFFFFFFFF, 1'b0, 12'h000, 32'h0},
    {1'b1, 12'h010, 32'hFFFFFFFF, 32'h0000FF00, 1'b1, 12'h010, 32'h12345678},
    {1'b0, 12'h000, 32'h0,        32'h0,        1'b1, 12'h010, 32'h1234FF78},
    {1'b1, 12'h011, 32'hA5A5A5A5, 32'hFFFFFFFF, 1'b1, 12'h010, 32'h1234FF78},
    {1'b1, 12'h011, 32'h00000000, 32'h80000001, 1'b0, 12'h000, 32'h0},
    {1'b0, 12'h000, 32'h0,        32'h0,        1'b1, 12'h011, 32'h25A5A5A4},
    {1'b1, 12'hFFF, 32'hCAFEF00D, 32'hFFFFFFFF, 1'b1, 12'h011, 32'h25A5A5A4},
    {1'b0, 12'h000, 32'h0,        32'h0,        1'b1, 12'hFFF, 32'hCAFEF00D},
    {1'b1, 12'hFFF, 32'h00000000, 32'h00000000, 1'b1, 12'hFFF, 32'hCAFEF00D},
    {1'b0, 12'h000, 32'h0,        32'h0,        1'b1, 12'hFFF, 32'hCAFEF00D}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  // waited instance
  logic          wr_en = 0, rd_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, wr_mask = '0;
  logic          wr_busy, wr_err, rd_busy, rd_valid, rd_err;
  logic [DW-1:0] rd_data;

  // zero-wait instance
  logic          z_wr_en = 0, z_rd_en = 0;
  logic [AW-1:0] z_wr_addr = '0, z_rd_addr = '0;
  logic [DW-1:0] z_wr_data = '0, z_wr_mask = '0;
  logic          z_wr_busy, z_wr_err, z_rd_busy, z_rd_valid, z_rd_err;
  logic [DW-1:0] z_rd_data;

  srw_mem_responder #(.DATA_W(DW), .ADDR_W(AW), .RD_WAIT(2), .WR_WAIT(3)) dut (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
    .wr_busy(wr_busy), .wr_err(wr_err),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_busy(rd_busy), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_err(rd_err)
  );

  srw_mem_responder #(.DATA_W(DW), .ADDR_W(AW), .RD_WAIT(0), .WR_WAIT(0)) dut_zw (
    .clk(clk), .rst(rst),
    .wr_en(z_wr_en), .wr_addr(z_wr_addr), .wr_data(z_wr_data), .wr_mask(z_wr_mask),
    .wr_busy(z_wr_busy), .wr_err(z_wr_err),
    .rd_en(z_rd_en), .rd_addr(z_rd_addr), .rd_busy(z_rd_busy), .rd_valid(z_rd_valid),
    .rd_data(z_rd_data), .rd_err(z_rd_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [DW-1:0] m);
    wr_en = 1; wr_addr = a; wr_data = d; wr_mask = m;
    @(negedge clk);
    wr_en = 0;
  endtask

  // pulse a read, then watch 6 cycles starting right after the request edge
  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d,
                         output int busy_n, output int vidx, output int vcnt);
    busy_n = 0; vidx = 0; vcnt = 0; d = '0;
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
    for (int i = 1; i <= 6; i++) begin
      if (rd_busy) busy_n++;
      if (rd_valid) begin
        vcnt++;
        vidx = i;
        d = rd_data;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    int bn, vi, vc, wb;

    repeat (3) @(negedge clk);
    rst = 0;
    // R7: reset state
    chk(!rd_busy && !wr_busy && !rd_valid && !rd_err && !wr_err, "R7", "reset state",
        {27'b0, rd_busy, wr_busy, rd_valid, rd_err, wr_err}, 32'h0);

    // vector walk on the zero-wait instance (R1, R6, R8)
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      z_wr_en   = v[VW-1];
      z_wr_addr = v[VW-2 -: AW];
      z_wr_data = v[VW-2-AW -: DW];
      z_wr_mask = v[VW-2-AW-DW -: DW];
      z_rd_en   = v[DW+AW];
      z_rd_addr = v[DW+AW-1 -: AW];
      @(negedge clk);
      chk(!z_rd_busy && !z_wr_busy, "R8", "zero-wait busy",
          {30'b0, z_rd_busy, z_wr_busy}, 32'h0);
      if (v[DW+AW]) begin
        chk(z_rd_valid && z_rd_data === v[DW-1:0], "R1 R6 R8", $sformatf("vector %0d read", i),
            z_rd_data, v[DW-1:0]);
      end
    end
    z_wr_en = 0; z_rd_en = 0;

    // R3: write busy window of 3
    do_write(12'h005, 32'hDEADBEEF, 32'hFFFFFFFF);
    wb = 0;
    for (int i = 0; i < 6; i++) begin
      if (wr_busy) wb++;
      @(negedge clk);
    end
    chk(wb == 3, "R3", "write busy cycles", wb, 3);

    // R2, R3: read timing with 2 wait states
    do_read(12'h005, d, bn, vi, vc);
    chk(bn == 2, "R3", "read busy cycles", bn, 2);
    chk(vi == 3, "R2", "valid cycle index", vi, 3);
    chk(vc == 1, "R2", "valid cycle count", vc, 1);
    chk(d === 32'hDEADBEEF, "R2", "read data", d, 32'hDEADBEEF);

    // R1: partial mask
    do_write(12'h005, 32'h00000000, 32'h0000FFFF);
    repeat (4) @(negedge clk);
    do_read(12'h005, d, bn, vi, vc);
    chk(d === 32'hDEAD0000, "R1", "masked write", d, 32'hDEAD0000);

    // R4: read and write together
    rd_en = 1; rd_addr = 12'h005;
    wr_en = 1; wr_addr = 12'h006; wr_data = 32'h0BADF00D; wr_mask = 32'hFFFFFFFF;
    @(negedge clk);
    rd_en = 0; wr_en = 0;
    chk(rd_busy && wr_busy, "R4", "both ports busy", {30'b0, rd_busy, wr_busy}, 32'h3);
    repeat (6) @(negedge clk);
    do_read(12'h006, d, bn, vi, vc);
    chk(d === 32'h0BADF00D, "R4", "concurrent write data", d, 32'h0BADF00D);

    // R5: read requested while busy
    rd_en = 1; rd_addr = 12'h005;
    @(negedge clk);
    rd_en = 1; rd_addr = 12'h006;
    @(negedge clk);
    rd_en = 0;
    chk(rd_err === 1'b1, "R5", "read error flag", rd_err, 1);
    @(negedge clk);
    chk(rd_valid && rd_data === 32'hDEAD0000, "R5", "first read kept", rd_data, 32'hDEAD0000);
    @(negedge clk);
    chk(!rd_valid && !rd_err && !rd_busy, "R5", "illegal read ignored",
        {29'b0, rd_valid, rd_err, rd_busy}, 32'h0);

    // R5: write requested while busy
    do_write(12'h006, 32'h00000000, 32'hFFFFFFFF);
    do_write(12'h006, 32'hFFFFFFFF, 32'hFFFFFFFF);
    chk(wr_err === 1'b1, "R5", "write error flag", wr_err, 1);
    repeat (4) @(negedge clk);
    do_read(12'h006, d, bn, vi, vc);
    chk(d === 32'h00000000, "R5", "illegal write ignored", d, 32'h0);

    // R7: reset during an outstanding read
    rd_en = 1; rd_addr = 12'h005;
    @(negedge clk);
    rd_en = 0; rst = 1;
    @(negedge clk);
    rst = 0;
    chk(!rd_busy && !rd_valid, "R7", "reset mid-read", {30'b0, rd_busy, rd_valid}, 32'h0);
    vc = 0;
    for (int i = 0; i < 4; i++) begin
      if (rd_valid) vc++;
      @(negedge clk);
    end
    chk(vc == 0, "R7", "pending read dropped", vc, 0);
    do_read(12'h005, d, bn, vi, vc);
    chk(d === 32'hDEAD0000, "R7", "memory kept over reset", d, 32'hDEAD0000);

    finish_run();
  end
endmodule